// File: doc/BRIEF.md
# Serial Configuration Byte Receiver

This block is a write-only serial slave for a three-wire mode-0 SPI link (active-low select, clock, data in). Each command is one byte whose bits arrive least significant first. When select returns high after a complete byte, the byte is committed. Bit 0 of the byte chooses which of two configuration registers it updates. One register holds a 5-bit offset trim code and the other a 4-bit gain code. The two top bits of every committed byte also set a power-down flag and a measure flag. A transfer that is cut short changes nothing.

The three SPI wires are asynchronous to the system clock. Each passes through a two-stage synchronizer. Edges are then found by comparing each synchronized value with its value one cycle earlier.

A framing state machine tracks each select window through four states:
- `ST_IDLE`: select is high.
- `ST_SHIFT`: bits are being collected.
- `ST_FULL`: the eighth rising clock edge has been seen.
- `ST_ARMED`: the falling clock edge after the eighth rise has been seen.

Its transitions are:
- IDLE→SHIFT on a select fall.
- SHIFT→FULL on the eighth rising clock edge.
- FULL→ARMED on the next falling clock edge.
- SHIFT/FULL/ARMED→IDLE on a select rise. Only a select rise from ARMED commits the byte.
- Any state goes to SHIFT on a select fall.

Top module: `cfgrx_top`

## Requirements
- R1: After reset, trim_code, gain_code, pwr_down, meas_en and wr_pulse are all zero.
- R2: Serial bits are sampled on rising clock edges in SPI mode 0. The first bit received becomes bit 0 of the byte and the eighth becomes bit 7.
- R3: A committed byte with bit 0 = 0 loads bits 5:1 into trim_code (bit 1 is the trim LSB) and leaves gain_code unchanged.
- R4: A committed byte with bit 0 = 1 loads bits 4:1 into gain_code (bit 1 is the gain LSB). Bit 5 is ignored and trim_code is left unchanged.
- R5: Every committed byte copies bit 7 to pwr_down and bit 6 to meas_en, whichever register it selects.
- R6: If select rises after fewer than eight rising clock edges, no output changes and no wr_pulse occurs.
- R7: If select rises after the eighth rising clock edge but before the falling edge that follows it, no output changes and no wr_pulse occurs.
- R8: Rising clock edges after the eighth within one select window are ignored. The byte committed is formed from the first eight bits.
- R9: The bit count restarts on every select fall, so a full byte sent after an aborted one commits correctly.
- R10: Each commit gives exactly one one-cycle wr_pulse. wr_sel equals bit 0 of the committed byte, and the register outputs already hold the new values in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low select, asynchronous |
| spi_sck | input | 1 | Serial clock, idles low, asynchronous |
| spi_mosi | input | 1 | Serial data in, LSB first, asynchronous |
| trim_code | output | 5 | Offset trim code |
| gain_code | output | 4 | Gain code |
| pwr_down | output | 1 | Power-down flag |
| meas_en | output | 1 | Measure-mode flag |
| wr_pulse | output | 1 | One-cycle strobe on each commit |
| wr_sel | output | 1 | Register just written: 0 trim, 1 gain |

## Verification
The bench aims at framing corner cases:
- A select rise after seven bits would commit a half-shifted byte in a design that counts wrongly.
- A select rise while the eighth clock is still high would commit early in a design that checks only rising edges.
- Extra clock pulses would corrupt the byte in a design whose counter does not saturate.
- A full byte right after an aborted one would be misaligned if the counter did not clear on select fall.

On the decode side, the bench uses two patterns. A byte whose bit order is asymmetric would select the wrong register if the bits were shifted MSB first. Gain writes with bit 5 set catch a decoder that takes the wrong field slice or lets a write to one register disturb the other.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2,
        ST_ARMED = 2'd3
    } rx_state_e;

    localparam int unsigned SEL_POS = 0;
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/cfgrx_frame.sv
module cfgrx_frame
    import cfgrx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic              commit,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_e        state, nxt;
    logic             cs_q, sck_q;
    logic             cs_fall, cs_rise, sck_rise, sck_fall;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n_s;
            sck_q <= sck_s;
        end
    end

    assign cs_fall  = cs_q & ~cs_n_s;
    assign cs_rise  = ~cs_q & cs_n_s;
    assign sck_rise = ~sck_q & sck_s;
    assign sck_fall = sck_q & ~sck_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cs_fall) begin
            nxt = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_SHIFT: if (cs_rise) nxt = ST_IDLE;
                          else if (sck_rise && cnt == LAST_BIT) nxt = ST_FULL;
                ST_FULL:  if (cs_rise) nxt = ST_IDLE;
                          else if (sck_fall) nxt = ST_ARMED;
                ST_ARMED: if (cs_rise) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit = (state == ST_ARMED) && cs_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_byte <= '0;
        end else if (cs_fall) begin
            cnt <= '0;
        end else if (sck_rise && state == ST_SHIFT) begin
            rx_byte <= {mosi_s, rx_byte[BYTE_W-1:1]};
            cnt     <= cnt + 1'b1;
        end
    end

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BYTE_W));
    a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> cnt == '0);
    a_r6_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cnt == CNT_W'(BYTE_W));
    a_r7_commit_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !sck_q);
endmodule

// File: rtl/cfgrx_regs.sv
module cfgrx_regs
    import cfgrx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned TRIM_W = 5,
    parameter int unsigned GAIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [TRIM_W-1:0] trim_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic              pwr_down,
    output logic              meas_en,
    output logic              wr_pulse,
    output logic              wr_sel
);
    localparam int unsigned PD_POS   = BYTE_W - 1;
    localparam int unsigned MEAS_POS = BYTE_W - 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_code <= '0;
            gain_code <= '0;
            pwr_down  <= 1'b0;
            meas_en   <= 1'b0;
            wr_pulse  <= 1'b0;
            wr_sel    <= 1'b0;
        end else begin
            wr_pulse <= commit;
            if (commit) begin
                wr_sel   <= rx_byte[SEL_POS];
                pwr_down <= rx_byte[PD_POS];
                meas_en  <= rx_byte[MEAS_POS];
                if (rx_byte[SEL_POS]) gain_code <= rx_byte[GAIN_W:1];
                else                  trim_code <= rx_byte[TRIM_W:1];
            end
        end
    end

    a_r3_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rx_byte[SEL_POS]) |=> $stable(gain_code));
    a_r4_trim_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rx_byte[SEL_POS]) |=> $stable(trim_code));
    a_r6_no_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({trim_code, gain_code, pwr_down, meas_en}));
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/cfgrx_top.sv
module cfgrx_top
    import cfgrx_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned TRIM_W      = 5,
    parameter int unsigned GAIN_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic [TRIM_W-1:0] trim_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic              pwr_down,
    output logic              meas_en,
    output logic              wr_pulse,
    output logic              wr_sel
);
    logic [2:0]        pins_s;
    logic              commit;
    logic [BYTE_W-1:0] rx_byte;

    cfgrx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_mosi, spi_sck, spi_cs_n}),
        .d_sync  (pins_s)
    );

    cfgrx_frame #(.BYTE_W(BYTE_W)) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[0]),
        .sck_s   (pins_s[1]),
        .mosi_s  (pins_s[2]),
        .commit  (commit),
        .rx_byte (rx_byte)
    );

    cfgrx_regs #(.BYTE_W(BYTE_W), .TRIM_W(TRIM_W), .GAIN_W(GAIN_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .rx_byte   (rx_byte),
        .trim_code (trim_code),
        .gain_code (gain_code),
        .pwr_down  (pwr_down),
        .meas_en   (meas_en),
        .wr_pulse  (wr_pulse),
        .wr_sel    (wr_sel)
    );
endmodule

// File: tb/cfgrx_top_tb_top.sv
`timescale 1ns/1ps
module cfgrx_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic [4:0] trim_code;
    logic [3:0] gain_code;
    logic pwr_down, meas_en, wr_pulse, wr_sel;

    always #10 clk = ~clk;

    cfgrx_top dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .trim_code(trim_code), .gain_code(gain_code), .pwr_down(pwr_down),
        .meas_en(meas_en), .wr_pulse(wr_pulse), .wr_sel(wr_sel)
    );

    int total = 0, bad = 0;
    bit done = 0;
    int pulses = 0;
    logic [4:0] snap_trim;
    logic [3:0] snap_gain;
    logic snap_pd, snap_meas, snap_sel;
    logic [4:0] e_trim = '0;
    logic [3:0] e_gain = '0;
    logic e_pd = 0, e_meas = 0;
    int e_pulses = 0;
    localparam int H = 3;

    always @(negedge clk) begin
        if (wr_pulse) begin
            pulses++;
            snap_trim = trim_code; snap_gain = gain_code;
            snap_pd = pwr_down; snap_meas = meas_en; snap_sel = wr_sel;
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model(logic [7:0] b);
        if (b[0]) e_gain = b[4:1];
        else      e_trim = b[5:1];
        e_pd = b[7];
        e_meas = b[6];
        e_pulses++;
    endfunction

    // kind: 0 full, 1 short, 2 extra clocks, 3 select rises with clock high
    task automatic xfer(logic [7:0] b, int kind, int nbits);
        int n;
        n = (kind == 1) ? nbits : (kind == 2 ? 8 + nbits : 8);
        @(negedge clk); cs_n = 1'b0; waitc(H);
        for (int i = 0; i < n; i++) begin
            mosi = (i < 8) ? b[i] : 1'($urandom);
            waitc(H); sck = 1'b1; waitc(H);
            if (kind == 3 && i == n - 1) begin
                cs_n = 1'b1; waitc(H);
            end
            sck = 1'b0;
        end
        waitc(H); cs_n = 1'b1; waitc(10);
        if (kind == 0 || kind == 2) model(b);
    endtask

    task automatic check_all(string req);
        chk({req, " trim"}, trim_code, e_trim);
        chk({req, " gain"}, gain_code, e_gain);
        chk({req, " pd"}, pwr_down, e_pd);
        chk({req, " meas"}, meas_en, e_meas);
        chk({req, " pulses"}, pulses, e_pulses);
    endtask

    task automatic check_snap(string req, logic [7:0] b);
        chk({req, " snap_sel"}, snap_sel, b[0]);
        chk({req, " snap_trim"}, snap_trim, e_trim);
        chk({req, " snap_gain"}, snap_gain, e_gain);
        chk({req, " snap_flags"}, {snap_pd, snap_meas}, {e_pd, e_meas});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int k;
        void'($urandom(32'd1234));
        waitc(3);
        // R1 reset state
        chk("R1 trim", trim_code, 0); chk("R1 gain", gain_code, 0);
        chk("R1 pd", pwr_down, 0); chk("R1 meas", meas_en, 0);
        chk("R1 pulse", wr_pulse, 0);
        rst_n = 1'b1; waitc(4);

        // R2/R3/R5: sel0, trim = 11011
        xfer(8'b1011_0110, 0, 0);
        chk("R2 lsb-first trim", trim_code, 27);
        check_all("R3"); check_snap("R10", 8'b1011_0110);
        // R4: sel1 with bit5 set, gain=0101
        xfer(8'b0110_1011, 0, 0);
        chk("R4 gain", gain_code, 5);
        check_all("R4"); check_snap("R10", 8'b0110_1011);
        // R5 flags via gain write
        xfer(8'b1100_0001, 0, 0); check_all("R5");
        // R6 short transfers
        xfer(8'b0011_1110, 1, 7); check_all("R6 seven bits");
        xfer(8'b1111_1111, 1, 0); check_all("R6 zero bits");
        // R7 select rises while eighth clock high
        xfer(8'b0011_1110, 3, 0); check_all("R7");
        // R8 extra clocks
        xfer(8'b0101_0100, 2, 3); check_all("R8");
        // R9 abort then full
        xfer(8'b1111_1111, 1, 5);
        xfer(8'b1000_0010, 0, 0); check_all("R9");

        for (int t = 0; t < 250; t++) begin
            b = 8'($urandom);
            k = $urandom_range(0, 3);
            xfer(b, k, (k == 1) ? $urandom_range(0, 7) : $urandom_range(1, 4));
            case (k)
                0: check_all("R3/R4/R5 random");
                1: check_all("R6 random");
                2: check_all("R8 random");
                default: check_all("R7 random");
            endcase
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule